// File: doc/BRIEF.md
# Tiled 2D Address Generator

This block maps a pixel coordinate inside a tiled two-dimensional container to a linear byte address in the tiled view. Each request carries a pixel format, three orientation flags and x/y pixel coordinates. The block rejects coordinates that fall outside the container. It applies axis mirroring by XOR with the field mask and can swap which axis supplies the high-order part of the offset. It scales the result by the format's geometry. It also returns the row stride that goes with the chosen format and orientation.

Requests enter through a valid/ready handshake. The result is held in one output register with its own valid/ready pair, so a consumer can stall the block without losing a result. The container size is set by bit-count parameters. The defaults describe 256 by 128 slots, with each slot 64 by 64 pixels in 8-bit format.

Top module: `tiled_addr_gen`

## Requirements
- R1: Format code 0 (8-bit) uses x shift 0 and y shift 0. With no orientation flags, the byte offset is (y << 14) + x, using the default x field of 14 bits and y field of 13 bits.
- R2: Format code 1 (16-bit) uses x shift 0 and y shift 1. The y field shrinks to 12 bits and the byte offset is ((y << 14) + x) << 1.
- R3: Format code 2 (32-bit) uses x shift 1 and y shift 1. The fields are 13 and 12 bits and the byte offset is ((y << 13) + x) << 2.
- R4: Format code 3 (page mode) uses the slot bit counts (6, 6) as its shifts. The fields are 8 and 7 bits and the byte offset is ((y << 8) + x) << 12.
- R5: If x is above its field's all-ones mask, or y is above its mask, the whole output address is 0 and the error output is 1. For every in-range coordinate the error output is 0, including one whose address is legitimately 0.
- R6: Orientation bit 0 replaces x with x XOR its field mask. Orientation bit 1 replaces y with y XOR its field mask. Both are applied before the offset is combined.
- R7: When orientation bit 2 (axis swap) is set, the combined offset is (x << y field width) + y instead of (y << x field width) + x.
- R8: For an accepted coordinate, the address carries the format code in bits [31:30], orientation bits 2,1,0 in bits [29:27], and the byte offset in bits [26:0].
- R9: The stride is 1 << (13 + x shift) when the axis swap is set, and 1 << (14 + y shift) otherwise.
- R10: The input is ready whenever the output register is empty or is being read in the same cycle. A request accepted at a clock edge is presented with output valid from that edge on. While output valid is high and output ready is low, the address, error and stride hold and no new request is taken.
- R11: During and right after reset, output valid is 0 and input ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Request present |
| inReady | output | 1 | Request can be taken this cycle |
| inFmt | input | 2 | Pixel format code: 0 8-bit, 1 16-bit, 2 32-bit, 3 page |
| inOrient | input | 3 | Bit 0 mirror x, bit 1 mirror y, bit 2 swap axes |
| inX | input | 16 | Pixel x coordinate |
| inY | input | 16 | Pixel y coordinate |
| outValid | output | 1 | Result register holds a result |
| outReady | input | 1 | Consumer takes the result this cycle |
| outAddr | output | 32 | Tiled-view address |
| outErr | output | 1 | Coordinate was out of range |
| outStride | output | 21 | Row stride in bytes |

## Verification
Every format is driven with small hand-computed coordinates. This shows whether each format uses the right field widths and scaling, because a wrong shift changes where the y term lands. Coordinates exactly at each field mask and one step past it separate the range boundary from an off-by-one. The origin with no flags tells a legitimate zero address apart from a rejected one. Each mirror flag alone, and the swap flag alone and combined with mirroring, show whether the XOR uses the field mask of the right axis and whether the swap exchanges the field widths. A stalled consumer with a second request waiting shows that results hold and that nothing is dropped or overwritten.

// File: rtl/tiled_addr_pkg.sv
package tiled_addr_pkg;

  typedef enum logic [1:0] {
    FMT_PIX8  = 2'd0,
    FMT_PIX16 = 2'd1,
    FMT_PIX32 = 2'd2,
    FMT_PAGE  = 2'd3
  } pixFmt_e;

  typedef struct packed {
    logic swapXY;
    logic mirrorY;
    logic mirrorX;
  } orient_t;

  typedef struct packed {
    logic load;
  } ctrlStrobe_t;

endpackage

// File: rtl/tiled_field_map.sv
module tiled_field_map
  import tiled_addr_pkg::*;
#(
  parameter int CONT_W_BITS = 14,
  parameter int CONT_H_BITS = 13,
  parameter int SLOT_W_BITS = 6,
  parameter int SLOT_H_BITS = 6,
  parameter int COORD_W     = 16,
  parameter int OFF_W       = CONT_W_BITS + CONT_H_BITS,
  parameter int STRIDE_W    = 21
) (
  input  pixFmt_e               fmt,
  input  orient_t               orient,
  input  logic [COORD_W-1:0]    xIn,
  input  logic [COORD_W-1:0]    yIn,
  output logic [OFF_W-1:0]      byteOff,
  output logic                  rangeErr,
  output logic [STRIDE_W-1:0]   stride
);

  localparam int WIDE = OFF_W + COORD_W + 2;

  logic [7:0]      xShift, yShift, xBits, yBits;
  logic [WIDE-1:0] xMask, yMask, xVal, yVal, combined, scaled;

  // geometry per format
  always_comb begin
    unique case (fmt)
      FMT_PIX8:  begin xShift = 8'd0; yShift = 8'd0; end
      FMT_PIX16: begin xShift = 8'd0; yShift = 8'd1; end
      FMT_PIX32: begin xShift = 8'd1; yShift = 8'd1; end
      default:   begin xShift = 8'(SLOT_W_BITS); yShift = 8'(SLOT_H_BITS); end
    endcase
    xBits = 8'(CONT_W_BITS) - xShift;
    yBits = 8'(CONT_H_BITS) - yShift;
  end

  // range check, mirroring and field combination
  always_comb begin
    xMask    = (WIDE'(1) << xBits) - WIDE'(1);
    yMask    = (WIDE'(1) << yBits) - WIDE'(1);
    xVal     = WIDE'(xIn);
    yVal     = WIDE'(yIn);
    rangeErr = (xVal > xMask) || (yVal > yMask);
    if (orient.mirrorX) xVal = xVal ^ xMask;
    if (orient.mirrorY) yVal = yVal ^ yMask;
    if (orient.swapXY) combined = (xVal << yBits) + yVal;
    else               combined = (yVal << xBits) + xVal;
    scaled  = combined << (xShift + yShift);
    byteOff = scaled[OFF_W-1:0];
  end

  // stride follows the axis that forms the high-order field
  always_comb begin
    if (orient.swapXY) stride = STRIDE_W'(1) << (8'(CONT_H_BITS) + xShift);
    else               stride = STRIDE_W'(1) << (8'(CONT_W_BITS) + yShift);
  end

endmodule

// File: rtl/tiled_addr_ctrl.sv
module tiled_addr_ctrl
  import tiled_addr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  output logic        outValid,
  input  logic        outReady,
  output ctrlStrobe_t strobe
);

  logic holdValid;

  assign inReady     = !holdValid || outReady;
  assign strobe.load = inValid && inReady;
  assign outValid    = holdValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            holdValid <= 1'b0;
    else if (strobe.load) holdValid <= 1'b1;
    else if (outReady)    holdValid <= 1'b0;
  end

endmodule

// File: rtl/tiled_addr_datapath.sv
module tiled_addr_datapath
  import tiled_addr_pkg::*;
#(
  parameter int CONT_W_BITS = 14,
  parameter int CONT_H_BITS = 13,
  parameter int SLOT_W_BITS = 6,
  parameter int SLOT_H_BITS = 6,
  parameter int COORD_W     = 16,
  parameter int ADDR_W      = 32,
  parameter int STRIDE_W    = 21
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [1:0]          inFmt,
  input  logic [2:0]          inOrient,
  input  logic [COORD_W-1:0]  inX,
  input  logic [COORD_W-1:0]  inY,
  output logic [ADDR_W-1:0]   outAddr,
  output logic                outErr,
  output logic [STRIDE_W-1:0] outStride
);

  localparam int OFF_W = CONT_W_BITS + CONT_H_BITS;

  logic [OFF_W-1:0]    byteOff;
  logic                rangeErr;
  logic [STRIDE_W-1:0] stride;
  logic [ADDR_W-1:0]   addrNext;

  tiled_field_map #(
    .CONT_W_BITS(CONT_W_BITS), .CONT_H_BITS(CONT_H_BITS),
    .SLOT_W_BITS(SLOT_W_BITS), .SLOT_H_BITS(SLOT_H_BITS),
    .COORD_W(COORD_W), .OFF_W(OFF_W), .STRIDE_W(STRIDE_W)
  ) u_map (
    .fmt     (pixFmt_e'(inFmt)),
    .orient  (orient_t'(inOrient)),
    .xIn     (inX),
    .yIn     (inY),
    .byteOff (byteOff),
    .rangeErr(rangeErr),
    .stride  (stride)
  );

  assign addrNext = rangeErr ? '0 : {inFmt, inOrient, byteOff};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outAddr   <= '0;
      outErr    <= 1'b0;
      outStride <= '0;
    end else if (strobe.load) begin
      outAddr   <= addrNext;
      outErr    <= rangeErr;
      outStride <= stride;
    end
  end

endmodule

// File: rtl/tiled_addr_gen.sv
module tiled_addr_gen
  import tiled_addr_pkg::*;
#(
  parameter int CONT_W_BITS = 14,
  parameter int CONT_H_BITS = 13,
  parameter int SLOT_W_BITS = 6,
  parameter int SLOT_H_BITS = 6,
  parameter int COORD_W     = 16,
  parameter int ADDR_W      = CONT_W_BITS + CONT_H_BITS + 5,
  parameter int STRIDE_W    = ((CONT_W_BITS > CONT_H_BITS) ? CONT_W_BITS : CONT_H_BITS)
                            + ((SLOT_W_BITS > SLOT_H_BITS) ? SLOT_W_BITS : SLOT_H_BITS) + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  output logic                inReady,
  input  logic [1:0]          inFmt,
  input  logic [2:0]          inOrient,
  input  logic [COORD_W-1:0]  inX,
  input  logic [COORD_W-1:0]  inY,
  output logic                outValid,
  input  logic                outReady,
  output logic [ADDR_W-1:0]   outAddr,
  output logic                outErr,
  output logic [STRIDE_W-1:0] outStride
);

  ctrlStrobe_t strobe;

  tiled_addr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .strobe(strobe)
  );

  tiled_addr_datapath #(
    .CONT_W_BITS(CONT_W_BITS), .CONT_H_BITS(CONT_H_BITS),
    .SLOT_W_BITS(SLOT_W_BITS), .SLOT_H_BITS(SLOT_H_BITS),
    .COORD_W(COORD_W), .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .inFmt(inFmt), .inOrient(inOrient), .inX(inX), .inY(inY),
    .outAddr(outAddr), .outErr(outErr), .outStride(outStride)
  );

endmodule

// File: rtl/tiled_addr_gen_checker.sv
module tiled_addr_gen_checker #(
  parameter int ADDR_W   = 32,
  parameter int STRIDE_W = 21
) (
  input logic                clk,
  input logic                rstN,
  input logic                inValid,
  input logic                inReady,
  input logic [1:0]          inFmt,
  input logic [2:0]          inOrient,
  input logic                outValid,
  input logic                outReady,
  input logic [ADDR_W-1:0]   outAddr,
  input logic                outErr,
  input logic [STRIDE_W-1:0] outStride
);

  assert_err_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outErr) |-> (outAddr == '0));

  assert_fields_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=>
      (outErr || (outAddr[ADDR_W-1 -: 5] == {$past(inFmt), $past(inOrient)})));

  assert_stride_pow2_R9: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ($countones(outStride) == 1));

  assert_accept_valid_R10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid);

  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=>
      (outValid && $stable(outAddr) && $stable(outErr) && $stable(outStride)));

  assert_idle_ready_R11: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> inReady);

endmodule

bind tiled_addr_gen tiled_addr_gen_checker #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .inFmt(inFmt), .inOrient(inOrient), .outValid(outValid), .outReady(outReady),
  .outAddr(outAddr), .outErr(outErr), .outStride(outStride)
);

// File: tb/sim_tiled_addr_gen.sv
module sim_tiled_addr_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [1:0]  inFmt = '0;
  logic [2:0]  inOrient = '0;
  logic [15:0] inX = '0;
  logic [15:0] inY = '0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [31:0] outAddr;
  logic        outErr;
  logic [20:0] outStride;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tiled_addr_gen u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inFmt(inFmt), .inOrient(inOrient), .inX(inX), .inY(inY),
    .outValid(outValid), .outReady(outReady), .outAddr(outAddr),
    .outErr(outErr), .outStride(outStride)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [1:0] f, input logic [2:0] o,
                                input logic [15:0] x, input logic [15:0] y,
                                output logic [31:0] a, output logic e,
                                output logic [20:0] s);
    int xs, ys, xb, yb;
    longint xm, ym, xx, yy, off;
    case (f)
      2'd0:    begin xs = 0; ys = 0; end
      2'd1:    begin xs = 0; ys = 1; end
      2'd2:    begin xs = 1; ys = 1; end
      default: begin xs = 6; ys = 6; end
    endcase
    xb = 14 - xs;
    yb = 13 - ys;
    xm = (longint'(1) << xb) - 1;
    ym = (longint'(1) << yb) - 1;
    e  = (longint'(x) > xm) || (longint'(y) > ym);
    xx = o[0] ? (longint'(x) ^ xm) : longint'(x);
    yy = o[1] ? (longint'(y) ^ ym) : longint'(y);
    off = o[2] ? ((xx << yb) + yy) : ((yy << xb) + xx);
    off = off << (xs + ys);
    a = e ? 32'd0 : {f, o, off[26:0]};
    s = o[2] ? (21'd1 << (13 + xs)) : (21'd1 << (14 + ys));
  endfunction

  // drive one request with the consumer ready, sample the registered result
  task automatic issue(input logic [1:0] f, input logic [2:0] o,
                       input logic [15:0] x, input logic [15:0] y);
    @(negedge clk);
    inFmt = f; inOrient = o; inX = x; inY = y;
    inValid = 1'b1; outReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic runCase(input string req, input logic [1:0] f, input logic [2:0] o,
                         input logic [15:0] x, input logic [15:0] y);
    logic [31:0] ea; logic ee; logic [20:0] es;
    model(f, o, x, y, ea, ee, es);
    issue(f, o, x, y);
    chk({req, " valid"}, 64'(outValid), 64'd1);
    chk({req, " addr"}, 64'(outAddr), 64'(ea));
    chk({req, " err"}, 64'(outErr), 64'(ee));
    chk({req, " stride"}, 64'(outStride), 64'(es));
  endtask

  task automatic testReset();
    chk("R11 reset outValid", 64'(outValid), 64'd0);
    chk("R11 reset inReady", 64'(inReady), 64'd1);
  endtask

  task automatic testFormats();
    issue(2'd0, 3'd0, 16'd5, 16'd3);
    chk("R1 8-bit addr", 64'(outAddr), 64'h0000C005);
    chk("R1 8-bit stride", 64'(outStride), 64'd16384);
    runCase("R1", 2'd0, 3'd0, 16'd1234, 16'd777);
    issue(2'd1, 3'd0, 16'd3, 16'd2);
    chk("R2 16-bit addr", 64'(outAddr), 64'h40010006);
    chk("R2 16-bit stride", 64'(outStride), 64'h8000);
    runCase("R2", 2'd1, 3'd0, 16'd9000, 16'd4000);
    issue(2'd2, 3'd0, 16'd1, 16'd1);
    chk("R3 32-bit addr", 64'(outAddr), 64'h80008004);
    runCase("R3", 2'd2, 3'd0, 16'd8191, 16'd100);
    issue(2'd3, 3'd0, 16'd255, 16'd127);
    chk("R4 page addr", 64'(outAddr), 64'hC7FFF000);
    runCase("R4", 2'd3, 3'd0, 16'd17, 16'd42);
  endtask

  task automatic testRange();
    runCase("R5 8-bit x at mask", 2'd0, 3'd0, 16'd16383, 16'd0);
    issue(2'd0, 3'd0, 16'd16384, 16'd0);
    chk("R5 8-bit x past mask err", 64'(outErr), 64'd1);
    chk("R5 8-bit x past mask addr", 64'(outAddr), 64'd0);
    runCase("R5 16-bit y at mask", 2'd1, 3'd5, 16'd0, 16'd4095);
    issue(2'd1, 3'd7, 16'd0, 16'd4096);
    chk("R5 16-bit y past mask err", 64'(outErr), 64'd1);
    chk("R5 16-bit y past mask addr", 64'(outAddr), 64'd0);
    issue(2'd3, 3'd0, 16'd256, 16'd0);
    chk("R5 page x past mask err", 64'(outErr), 64'd1);
    issue(2'd0, 3'd0, 16'd0, 16'd0);
    chk("R5 legit zero addr", 64'(outAddr), 64'd0);
    chk("R5 legit zero no err", 64'(outErr), 64'd0);
  endtask

  task automatic testMirror();
    issue(2'd0, 3'b001, 16'd0, 16'd0);
    chk("R6 mirror x addr", 64'(outAddr), 64'h08003FFF);
    issue(2'd2, 3'b010, 16'd0, 16'd0);
    chk("R6 mirror y addr", 64'(outAddr), 64'h97FF8000);
    runCase("R6 both mirrors", 2'd1, 3'b011, 16'd77, 16'd3000);
  endtask

  task automatic testSwap();
    issue(2'd0, 3'b100, 16'd1, 16'd2);
    chk("R7 swap addr", 64'(outAddr), 64'h20002002);
    chk("R9 swap stride 8-bit", 64'(outStride), 64'h2000);
    issue(2'd3, 3'b100, 16'd2, 16'd1);
    chk("R7 swap page addr", 64'(outAddr), 64'hE0101000);
    chk("R9 swap stride page", 64'(outStride), 64'h80000);
    runCase("R7 swap with mirrors", 2'd2, 3'b111, 16'd500, 16'd60);
  endtask

  task automatic testFields();
    issue(2'd2, 3'b101, 16'd3, 16'd4);
    chk("R8 format field", 64'(outAddr[31:30]), 64'd2);
    chk("R8 orient field", 64'(outAddr[29:27]), 64'd5);
    runCase("R8", 2'd3, 3'b110, 16'd200, 16'd9);
  endtask

  task automatic testStride();
    runCase("R9 32-bit", 2'd2, 3'd0, 16'd0, 16'd0);
    runCase("R9 page", 2'd3, 3'd0, 16'd0, 16'd0);
  endtask

  task automatic testBackpressure();
    @(negedge clk);
    inFmt = 2'd0; inOrient = 3'd0; inX = 16'd10; inY = 16'd1;
    inValid = 1'b1; outReady = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R10 first result valid", 64'(outValid), 64'd1);
    chk("R10 first result addr", 64'(outAddr), 64'h0000400A);
    inFmt = 2'd2; inX = 16'd1; inY = 16'd1;
    chk("R10 stalled not ready", 64'(inReady), 64'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R10 held addr", 64'(outAddr), 64'h0000400A);
    @(posedge clk);
    @(negedge clk);
    chk("R10 still held", 64'(outAddr), 64'h0000400A);
    outReady = 1'b1;
    #1;
    chk("R10 ready when drained", 64'(inReady), 64'd1);
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    chk("R10 second result", 64'(outAddr), 64'h80008004);
    chk("R10 second valid", 64'(outValid), 64'd1);
    @(posedge clk);
    @(negedge clk);
    chk("R10 drained", 64'(outValid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFormats();
    testRange();
    testMirror();
    testSwap();
    testFields();
    testStride();
    testBackpressure();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule